// File: doc/BRIEF.md
# Erase-Block Endurance and Defect Table

This block holds one small record for each erase block of a simulated flash array. A record has a remaining-endurance counter and a factory-defect flag. An initialization run is started with a single pulse and a wear limit. The run clears all defect flags and presets every counter. It then takes a stream of 32-bit defect indices, one per cycle, and sets the defect flag of each block named. After that, every erase reported on the erase input wears down the counter of the block it names. A query port gives a combinational answer on whether a block can still be used, together with its remaining endurance.

Control is a four-state machine:
- **UNINIT** is the state after reset.
- **LOAD** is entered from any state on `init_start`.
- **READY** is entered from LOAD on the list terminator or when the list reaches its entry limit.
- **FAULT** is entered from LOAD when an index is out of range.

Only `init_start` leaves READY or FAULT, and it always leads to LOAD. Queries and erases take effect only in READY.

Top module: `flash_block_health`

## Requirements
- R1: After reset the state is UNINIT, and `qry_ok`, `qry_wear`, `init_done` and `init_err` are all 0.
- R2: `init_start` clears every defect flag and presets every counter on the next edge. A nonzero `cfg_wear_limit` is loaded as the counter value. A zero limit loads the all-ones sentinel (255 for 8-bit counters), which stands for unlimited endurance. A configured limit of all ones behaves like the sentinel.
- R3: In LOAD, each cycle with `list_valid` high accepts one `list_idx`. The value 0xFFFFFFFF ends the list. `init_done` is high for exactly the one cycle that follows the edge which accepted the last entry.
- R4: Once MAX_LIST (default 8) non-terminator entries have been accepted, loading ends and `init_done` pulses. Further list entries are ignored.
- R5: An index not below the total block count (BLOCKS_PER_UNIT × UNITS, default 24, so the valid indices are 0..23) ends loading in FAULT. In that case `init_done` pulses and `init_err` rises together with it. `init_err` stays high until the next `init_start`, and every query reports unusable while the block is in FAULT.
- R6: An accepted in-range index sets that block's defect flag. The block then queries as unusable while its counter keeps its preset value.
- R7: In READY, `qry_wear` shows the counter of `qry_blk`. `qry_ok` is 1 exactly when that block's defect flag is clear and its counter is nonzero. An out-of-range `qry_blk` gives 0 on both outputs.
- R8: In READY, an erase lowers the named block's counter by one on the next edge. A counter of zero stays at zero, and the sentinel never changes.
- R9: Outside READY, erases leave every counter unchanged, and the query outputs read 0.
- R10: When an erase and a query name the same block in the same cycle, the query shows the value before the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_start | input | 1 | Starts an initialization run |
| cfg_wear_limit | input | WEAR_W | Endurance preset, sampled with init_start |
| list_valid | input | 1 | A defect-list entry is present |
| list_idx | input | 32 | Defect-list entry (0xFFFFFFFF ends the list) |
| init_done | output | 1 | One-cycle pulse when loading ends |
| init_err | output | 1 | The last run aborted on a bad index |
| erase_valid | input | 1 | An erase was performed |
| erase_blk | input | BLK_W | Index of the erased block |
| qry_blk | input | BLK_W | Block index to query |
| qry_ok | output | 1 | The queried block is usable |
| qry_wear | output | WEAR_W | Remaining endurance of the queried block |

## Verification
A counter that is decremented wrongly first shows up on `qry_wear` in the cycle after the erase, provided the same block is held on the query port. A lost or misplaced defect mark shows up at once as a wrong `qry_ok` for that index once READY is reached. A state machine that ends loading early or late moves the `init_done` pulse away from the cycle after the terminating entry. It also lets a later list entry mark a block that should have stayed usable.

// File: rtl/fbh_pkg.sv
package fbh_pkg;
    typedef enum logic [1:0] {
        FBH_UNINIT = 2'd0,
        FBH_LOAD   = 2'd1,
        FBH_READY  = 2'd2,
        FBH_FAULT  = 2'd3
    } fbh_state_t;

    localparam logic [31:0] FBH_LIST_END = 32'hFFFF_FFFF;
endpackage

// File: rtl/fbh_init_fsm.sv
module fbh_init_fsm
    import fbh_pkg::*;
#(
    parameter int TOTAL    = 24,
    parameter int MAX_LIST = 8,
    parameter int BLK_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_start,
    input  logic             list_valid,
    input  logic [31:0]      list_idx,
    output fbh_state_t       st,
    output logic             mark_en,
    output logic [BLK_W-1:0] mark_idx,
    output logic             init_done,
    output logic             init_err
);
    localparam int          CNT_W     = $clog2(MAX_LIST + 1);
    localparam logic [31:0] TOTAL_32  = 32'(TOTAL);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_LIST - 1);

    fbh_state_t       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             done_q, done_n;
    logic             err_q, err_n;
    logic             mark_n;

    // next-state and output decisions
    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        done_n = 1'b0;
        err_n  = err_q;
        mark_n = 1'b0;
        if (init_start) begin
            st_n  = FBH_LOAD;
            cnt_n = '0;
            err_n = 1'b0;
        end else begin
            unique case (st_q)
                FBH_LOAD: begin
                    if (list_valid) begin
                        if (list_idx == FBH_LIST_END) begin
                            st_n   = FBH_READY;
                            done_n = 1'b1;
                        end else if (list_idx >= TOTAL_32) begin
                            st_n   = FBH_FAULT;
                            done_n = 1'b1;
                            err_n  = 1'b1;
                        end else begin
                            mark_n = 1'b1;
                            if (cnt_q == LAST) begin
                                st_n   = FBH_READY;
                                done_n = 1'b1;
                            end else begin
                                cnt_n = cnt_q + 1'b1;
                            end
                        end
                    end
                end
                FBH_UNINIT, FBH_READY, FBH_FAULT: ;
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FBH_UNINIT;
        else        st_q <= st_n;
    end

    // output and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            done_q <= done_n;
            err_q  <= err_n;
        end
    end

    assign st        = st_q;
    assign mark_en   = mark_n;
    assign mark_idx  = list_idx[BLK_W-1:0];
    assign init_done = done_q;
    assign init_err  = err_q;
endmodule

// File: rtl/fbh_entry.sv
module fbh_entry #(
    parameter int WEAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [WEAR_W-1:0] clr_val,
    input  logic              mark,
    input  logic              erase,
    output logic [WEAR_W-1:0] cnt,
    output logic              bad
);
    localparam logic [WEAR_W-1:0] SENT = {WEAR_W{1'b1}};

    logic [WEAR_W-1:0] cnt_q;
    logic              bad_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bad_q <= 1'b0;
        end else if (clr) begin
            cnt_q <= clr_val;
            bad_q <= 1'b0;
        end else begin
            if (mark) bad_q <= 1'b1;
            if (erase && (cnt_q != '0) && (cnt_q != SENT))
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt = cnt_q;
    assign bad = bad_q;
endmodule

// File: rtl/fbh_query.sv
module fbh_query #(
    parameter int TOTAL  = 24,
    parameter int WEAR_W = 8,
    parameter int BLK_W  = 5
) (
    input  logic              ready,
    input  logic [BLK_W-1:0]  qry_blk,
    input  logic [WEAR_W-1:0] cnt_arr [TOTAL],
    input  logic [TOTAL-1:0]  bad_vec,
    output logic              qry_ok,
    output logic [WEAR_W-1:0] qry_wear
);
    localparam logic [BLK_W:0] TOTAL_X = (BLK_W + 1)'(TOTAL);

    always_comb begin
        qry_ok   = 1'b0;
        qry_wear = '0;
        if (ready && ({1'b0, qry_blk} < TOTAL_X)) begin
            qry_wear = cnt_arr[qry_blk];
            qry_ok   = !bad_vec[qry_blk] && (cnt_arr[qry_blk] != '0);
        end
    end
endmodule

// File: rtl/flash_block_health.sv
module flash_block_health
    import fbh_pkg::*;
#(
    parameter  int BLOCKS_PER_UNIT = 12,
    parameter  int UNITS           = 2,
    parameter  int WEAR_W          = 8,
    parameter  int MAX_LIST        = 8,
    localparam int TOTAL           = BLOCKS_PER_UNIT * UNITS,
    localparam int BLK_W           = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_start,
    input  logic [WEAR_W-1:0] cfg_wear_limit,
    input  logic              list_valid,
    input  logic [31:0]       list_idx,
    output logic              init_done,
    output logic              init_err,
    input  logic              erase_valid,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic [BLK_W-1:0]  qry_blk,
    output logic              qry_ok,
    output logic [WEAR_W-1:0] qry_wear
);
    localparam logic [WEAR_W-1:0] SENT = {WEAR_W{1'b1}};

    fbh_state_t        st;
    logic              mark_en;
    logic [BLK_W-1:0]  mark_idx;
    logic              ready;
    logic [WEAR_W-1:0] preset;
    logic [WEAR_W-1:0] cnt_arr [TOTAL];
    logic [TOTAL-1:0]  bad_vec;

    fbh_init_fsm #(
        .TOTAL   (TOTAL),
        .MAX_LIST(MAX_LIST),
        .BLK_W   (BLK_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_start(init_start),
        .list_valid(list_valid),
        .list_idx  (list_idx),
        .st        (st),
        .mark_en   (mark_en),
        .mark_idx  (mark_idx),
        .init_done (init_done),
        .init_err  (init_err)
    );

    assign ready  = (st == FBH_READY);
    assign preset = (cfg_wear_limit == '0) ? SENT : cfg_wear_limit;

    for (genvar g = 0; g < TOTAL; g++) begin : g_entry
        logic hit_mark;
        logic hit_erase;
        assign hit_mark  = mark_en && (mark_idx == BLK_W'(g));
        assign hit_erase = ready && erase_valid && (erase_blk == BLK_W'(g));
        fbh_entry #(
            .WEAR_W(WEAR_W)
        ) u_ent (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (init_start),
            .clr_val(preset),
            .mark   (hit_mark),
            .erase  (hit_erase),
            .cnt    (cnt_arr[g]),
            .bad    (bad_vec[g])
        );
    end

    fbh_query #(
        .TOTAL (TOTAL),
        .WEAR_W(WEAR_W),
        .BLK_W (BLK_W)
    ) u_qry (
        .ready   (ready),
        .qry_blk (qry_blk),
        .cnt_arr (cnt_arr),
        .bad_vec (bad_vec),
        .qry_ok  (qry_ok),
        .qry_wear(qry_wear)
    );
endmodule

// File: rtl/fbh_checker.sv
module fbh_checker
    import fbh_pkg::*;
#(
    parameter int WEAR_W = 8,
    parameter int BLK_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input fbh_state_t        st,
    input logic              init_start,
    input logic              init_done,
    input logic              init_err,
    input logic              erase_valid,
    input logic [BLK_W-1:0]  erase_blk,
    input logic [BLK_W-1:0]  qry_blk,
    input logic              qry_ok,
    input logic [WEAR_W-1:0] qry_wear
);
    localparam logic [WEAR_W-1:0] SENT = {WEAR_W{1'b1}};

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> !init_done);

    assert_err_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (init_err && !init_start) |=> init_err);

    assert_ok_needs_wear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        qry_ok |-> (qry_wear != '0));

    assert_quiet_unready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != FBH_READY) |-> (!qry_ok && qry_wear == '0));

    assert_erase_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FBH_READY && !init_start && erase_valid && erase_blk == qry_blk &&
         qry_wear != '0 && qry_wear != SENT)
        |=> ($stable(qry_blk) -> (qry_wear == WEAR_W'($past(qry_wear) - 1'b1))));

    assert_sentinel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FBH_READY && !init_start && qry_wear == SENT)
        |=> ($stable(qry_blk) -> (qry_wear == SENT)));

    assert_zero_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FBH_READY && !init_start && qry_wear == '0)
        |=> ($stable(qry_blk) -> (qry_wear == '0)));
endmodule

bind flash_block_health fbh_checker #(
    .WEAR_W(WEAR_W),
    .BLK_W (BLK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .init_start (init_start),
    .init_done  (init_done),
    .init_err   (init_err),
    .erase_valid(erase_valid),
    .erase_blk  (erase_blk),
    .qry_blk    (qry_blk),
    .qry_ok     (qry_ok),
    .qry_wear   (qry_wear)
);

// File: tb/flash_block_health_tb.sv
module flash_block_health_tb;
    localparam int WEAR_W = 8;
    localparam int BLK_W  = 5;

    typedef struct {
        int    blk;
        int    ok;
        int    wear;
        string req;
    } probe_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              init_start = 1'b0;
    logic [WEAR_W-1:0] cfg_wear_limit = '0;
    logic              list_valid = 1'b0;
    logic [31:0]       list_idx = '0;
    logic              init_done;
    logic              init_err;
    logic              erase_valid = 1'b0;
    logic [BLK_W-1:0]  erase_blk = '0;
    logic [BLK_W-1:0]  qry_blk = '0;
    logic              qry_ok;
    logic [WEAR_W-1:0] qry_wear;

    int     checks = 0;
    int     failures = 0;
    bit     finished = 1'b0;
    probe_t sb[$];
    event   probe_ev;

    always #4 clk = ~clk;

    flash_block_health u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .init_start    (init_start),
        .cfg_wear_limit(cfg_wear_limit),
        .list_valid    (list_valid),
        .list_idx      (list_idx),
        .init_done     (init_done),
        .init_err      (init_err),
        .erase_valid   (erase_valid),
        .erase_blk     (erase_blk),
        .qry_blk       (qry_blk),
        .qry_ok        (qry_ok),
        .qry_wear      (qry_wear)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: set the query and push the expected answer
    task automatic probe(int blk, int ok, int wear, string req);
        probe_t p;
        qry_blk = BLK_W'(blk);
        p.blk = blk; p.ok = ok; p.wear = wear; p.req = req;
        sb.push_back(p);
        -> probe_ev;
    endtask

    // monitor: sample between edges and compare against the scoreboard
    initial begin
        forever begin
            @(probe_ev);
            #1;
            if (sb.size() > 0) begin
                probe_t p;
                p = sb.pop_front();
                check({p.req, " ok"}, int'(qry_ok), p.ok);
                check({p.req, " wear"}, int'(qry_wear), p.wear);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic begin_init(int limit);
        init_start = 1'b1;
        cfg_wear_limit = WEAR_W'(limit);
        tick();
        init_start = 1'b0;
    endtask

    task automatic feed(logic [31:0] idx);
        list_valid = 1'b1;
        list_idx = idx;
        tick();
        list_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        check("R1 done", int'(init_done), 0);
        check("R1 err", int'(init_err), 0);
        probe(0, 0, 0, "R1 query");
        rst_n = 1'b1;
        tick();
        probe(3, 0, 0, "R9 uninit query");
        tick();

        // init with limit 3, defects 5 and 23
        begin_init(3);
        erase_valid = 1'b1;
        erase_blk = 5'd0;
        probe(0, 0, 0, "R9 loading query");
        feed(32'd5);
        erase_valid = 1'b0;
        feed(32'd23);
        check("R3 no early done", int'(init_done), 0);
        feed(32'hFFFF_FFFF);
        check("R3 done pulse", int'(init_done), 1);
        check("R3 no err", int'(init_err), 0);
        tick();
        check("R3 done width", int'(init_done), 0);
        probe(5, 0, 3, "R6 defect mark");
        tick();
        probe(23, 0, 3, "R6 last index");
        tick();
        probe(0, 1, 3, "R9 erase in load ignored");
        tick();
        probe(22, 1, 3, "R2 preset");
        tick();
        probe(30, 0, 0, "R7 out of range query");
        tick();

        // erase and query on the same block
        erase_valid = 1'b1;
        erase_blk = 5'd0;
        probe(0, 1, 3, "R10 pre-decrement view");
        tick();
        erase_valid = 1'b0;
        probe(0, 1, 2, "R8 decrement");
        tick();
        erase_valid = 1'b1;
        tick();
        tick();
        probe(0, 0, 0, "R7 worn out");
        tick();
        erase_valid = 1'b0;
        probe(0, 0, 0, "R8 floor at zero");
        tick();
        probe(1, 1, 3, "R8 other block untouched");
        tick();

        // out-of-range index aborts
        begin_init(0);
        feed(32'd24);
        check("R5 done on abort", int'(init_done), 1);
        check("R5 err", int'(init_err), 1);
        probe(1, 0, 0, "R5 faulted query");
        tick();
        tick();
        check("R5 err holds", int'(init_err), 1);

        // list limit reached without terminator
        begin_init(0);
        check("R5 err cleared", int'(init_err), 0);
        for (int i = 0; i < 7; i++) feed(32'(i));
        check("R4 not done yet", int'(init_done), 0);
        feed(32'd7);
        check("R4 done at limit", int'(init_done), 1);
        feed(32'd9);
        check("R4 extra entry no done", int'(init_done), 0);
        probe(7, 0, 255, "R6 eighth entry marked");
        tick();
        probe(9, 1, 255, "R4 extra entry ignored");
        tick();
        erase_valid = 1'b1;
        erase_blk = 5'd9;
        tick();
        erase_valid = 1'b0;
        probe(9, 1, 255, "R8 sentinel holds");
        tick();

        // all-ones limit behaves as sentinel
        begin_init(255);
        feed(32'hFFFF_FFFF);
        probe(2, 1, 255, "R2 all-ones limit");
        erase_valid = 1'b1;
        erase_blk = 5'd2;
        tick();
        erase_valid = 1'b0;
        probe(2, 1, 255, "R2 all-ones no wear");
        tick();

        repeat (3) tick();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule